// File: doc/BRIEF.md
# Pipelined Burst Synchronous SRAM Core

This block is a clocked memory of 36-bit words, each made of four 9-bit byte lanes. At every rising clock edge it samples an address, write data, three chip-enable inputs, two burst-start strobes, an advance input and the write controls. It then decides what the cycle is: a deselect, the start of a new read or write at the external address, a step to the next address of a four-word burst, or a pause at the current burst address. Read data leaves through an output register, one clock later than the access.

There are two burst-start strobes. The processor-side strobe can only start reads, and it is ignored while the primary chip select is inactive. The controller-side strobe can start reads or writes, and it deselects the block when the chip is not enabled. Burst addresses change only the two low address bits and wrap after four words, in either linear or interleaved order, chosen by a static mode input. An asynchronous output enable gates the data-drive flag. The tri-state data pins are modelled as separate input and output buses plus a drive flag. Holding the controller strobe low and the advance input high on every cycle gives plain non-burst operation.

Top module: `burst_sram_core`

## Requirements
- R1: With `globalWrN` high and `writeN` low, only the lanes whose `laneWrN[i]` is low are written. Lane i is bits [9i+8:9i]. The other lanes keep their old contents.
- R2: `globalWrN` low writes all four lanes, whatever the values of `writeN` and `laneWrN`.
- R3: A cycle with both `globalWrN` and `writeN` high is a read, even when `laneWrN` bits are low. No cycle both reads and writes.
- R4: `procStartN` low with the chip enabled starts a read at `addrIn`. The write controls are ignored in that cycle. The chip is enabled when `chipSelN` is low, `chipEnHi` is high and `chipEnLoN` is low.
- R5: `ctrlStartN` low with the chip not enabled (and no valid processor start) deselects the block. No data is driven for that cycle, and the burst in progress ends, so later advance cycles do nothing.
- R6: `procStartN` low while `chipSelN` is high has no effect. The burst in progress continues under control of `advN`.
- R7: Read data for an access sampled at edge n appears on `dataOut` with `dataDrive` high after edge n+1.
- R8: `outEnN` high forces `dataDrive` low at once, without waiting for a clock edge. Lowering it re-enables the pending data.
- R9: In linear mode (`interleaveMode` low), step k of a burst uses low address bits equal to start+k modulo 4. The upper address bits are kept, and the burst wraps after the fourth word.
- R10: In interleaved mode (`interleaveMode` high), step k of a burst uses low address bits equal to start XOR k.
- R11: A cycle with both strobes high and `advN` high stays at the current burst address. In a read burst that word is read again; in a write burst that word is written again.
- R12: A cycle with both strobes high continues the burst in the direction it started, whatever the chip enables are. In a write burst, that cycle's write controls pick the lanes.
- R13: With `ctrlStartN` low and the chip enabled on every cycle, each cycle is an independent read or write at a fresh external address.
- R14: Synchronous reset `rst` leaves the block deselected with `dataDrive` low, and it ends any burst in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all sampling on the rising edge |
| rst | input | 1 | Synchronous reset, active high |
| addrIn | input | ADDR_W | External word address |
| dataIn | input | 36 | Write data bus |
| chipSelN | input | 1 | Primary chip select, active low; also gates the processor strobe |
| chipEnHi | input | 1 | Depth-expansion enable, active high |
| chipEnLoN | input | 1 | Depth-expansion enable, active low |
| procStartN | input | 1 | Processor burst-start strobe, active low, reads only |
| ctrlStartN | input | 1 | Controller burst-start strobe, active low |
| advN | input | 1 | Burst advance, active low; high pauses the burst |
| globalWrN | input | 1 | Write all lanes, active low |
| writeN | input | 1 | Write the lanes selected by laneWrN, active low |
| laneWrN | input | 4 | Per-lane write selects, active low |
| interleaveMode | input | 1 | Static burst order: 0 linear, 1 interleaved |
| outEnN | input | 1 | Asynchronous output enable, active low |
| dataOut | output | 36 | Read data (zero when not driven) |
| dataDrive | output | 1 | High while dataOut is being driven |

## Verification
The assertions assume that `interleaveMode` does not change while a burst is active. They also assume that reset is applied before the first access, so the burst state and the read pipeline start out empty. The stimulus changes the mode only after a deselect has ended the previous burst. The stimulus applies every input half a cycle away from the sampling edge. It reads back only addresses it has written earlier, so every expected word is fully defined.

// File: rtl/burst_sram_pkg.sv
package burst_sram_pkg;
  localparam int LANES  = 4;
  localparam int LANE_W = 9;
  localparam int WORD_W = LANES * LANE_W;
  localparam int BURST_W = 2;

  // strobes from control to datapath for one sampled cycle
  typedef struct packed {
    logic             rdEn;
    logic             wrEn;
    logic [LANES-1:0] laneMask;
  } sram_strobe_t;

  typedef enum logic [1:0] {
    DIR_IDLE  = 2'd0,
    DIR_READ  = 2'd1,
    DIR_WRITE = 2'd2
  } burst_dir_t;
endpackage

// File: rtl/burst_sram_ctrl.sv
module burst_sram_ctrl
  import burst_sram_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] addrIn,
  input  logic              chipSelN,
  input  logic              chipEnHi,
  input  logic              chipEnLoN,
  input  logic              procStartN,
  input  logic              ctrlStartN,
  input  logic              advN,
  input  logic              globalWrN,
  input  logic              writeN,
  input  logic [LANES-1:0]  laneWrN,
  input  logic              interleaveMode,
  output sram_strobe_t      strobe,
  output logic [ADDR_W-1:0] accAddr
);
  burst_dir_t dirQ, newDir;
  logic [ADDR_W-1:0] baseQ;
  logic [BURST_W-1:0] cntQ, cntStep, lowBits;
  logic [LANES-1:0] reqMask;
  logic chipOn, procHit, wantWrite, startNew, endBurst;

  always_comb begin
    chipOn    = !chipSelN && chipEnHi && !chipEnLoN;
    procHit   = !procStartN && !chipSelN;
    reqMask   = !globalWrN ? '1 : (!writeN ? ~laneWrN : '0);
    wantWrite = |reqMask;
    cntStep   = advN ? cntQ : cntQ + 1'b1;
    lowBits   = interleaveMode ? (baseQ[BURST_W-1:0] ^ cntStep)
                               : (baseQ[BURST_W-1:0] + cntStep);

    startNew = 1'b0;
    endBurst = 1'b0;
    newDir   = DIR_READ;
    strobe   = '0;
    accAddr  = {baseQ[ADDR_W-1:BURST_W], lowBits};

    if (rst) begin
      endBurst = 1'b1;
    end else if (procHit) begin
      if (chipOn) begin
        startNew    = 1'b1;
        accAddr     = addrIn;
        strobe.rdEn = 1'b1;
      end else begin
        endBurst = 1'b1;
      end
    end else if (!ctrlStartN) begin
      if (chipOn) begin
        startNew = 1'b1;
        accAddr  = addrIn;
        if (wantWrite) begin
          newDir          = DIR_WRITE;
          strobe.wrEn     = 1'b1;
          strobe.laneMask = reqMask;
        end else begin
          strobe.rdEn = 1'b1;
        end
      end else begin
        endBurst = 1'b1;
      end
    end else if (dirQ == DIR_READ) begin
      strobe.rdEn = 1'b1;
    end else if (dirQ == DIR_WRITE) begin
      strobe.wrEn     = wantWrite;
      strobe.laneMask = reqMask;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      dirQ  <= DIR_IDLE;
      baseQ <= '0;
      cntQ  <= '0;
    end else if (startNew) begin
      dirQ  <= newDir;
      baseQ <= addrIn;
      cntQ  <= '0;
    end else if (endBurst) begin
      dirQ <= DIR_IDLE;
    end else if (dirQ != DIR_IDLE) begin
      cntQ <= cntStep;
    end
  end

  assert_proc_start_reads_R4: assert property (@(posedge clk) disable iff (rst)
    (!procStartN && !chipSelN && chipEnHi && !chipEnLoN) |-> (strobe.rdEn && !strobe.wrEn));

  assert_deselect_quiet_R5: assert property (@(posedge clk) disable iff (rst)
    ((procStartN || chipSelN) && !ctrlStartN && (chipSelN || !chipEnHi || chipEnLoN))
      |-> (!strobe.rdEn && !strobe.wrEn));

  assert_suspend_holds_R11: assert property (@(posedge clk) disable iff (rst)
    ((procStartN || chipSelN) && ctrlStartN && advN && dirQ != DIR_IDLE)
      |-> (accAddr == $past(accAddr)));

  assert_burst_keeps_write_R12: assert property (@(posedge clk) disable iff (rst)
    (dirQ == DIR_WRITE && (procStartN || chipSelN) && ctrlStartN && !globalWrN)
      |-> (strobe.wrEn && strobe.laneMask == '1 && !strobe.rdEn));
endmodule

// File: rtl/burst_sram_dpath.sv
module burst_sram_dpath
  import burst_sram_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  sram_strobe_t      strobe,
  input  logic [ADDR_W-1:0] accAddr,
  input  logic [WORD_W-1:0] dataIn,
  input  logic              outEnN,
  output logic [WORD_W-1:0] dataOut,
  output logic              dataDrive
);
  localparam int DEPTH = 1 << ADDR_W;

  logic rdPendQ, outValidQ;
  logic [ADDR_W-1:0] rdAddrQ;
  logic [WORD_W-1:0] wordQ;

  for (genvar g = 0; g < LANES; g++) begin : gLane
    logic [LANE_W-1:0] laneMem [DEPTH];
    logic [LANE_W-1:0] laneOutQ;
    always_ff @(posedge clk) begin
      if (strobe.wrEn && strobe.laneMask[g])
        laneMem[accAddr] <= dataIn[g*LANE_W +: LANE_W];
      if (rdPendQ)
        laneOutQ <= laneMem[rdAddrQ];
    end
    assign wordQ[g*LANE_W +: LANE_W] = laneOutQ;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rdPendQ   <= 1'b0;
      outValidQ <= 1'b0;
    end else begin
      rdPendQ   <= strobe.rdEn;
      outValidQ <= rdPendQ;
    end
    rdAddrQ <= accAddr;
  end

  assign dataDrive = outValidQ && !outEnN;
  assign dataOut   = dataDrive ? wordQ : '0;

  assert_one_direction_R3: assert property (@(posedge clk) disable iff (rst)
    $onehot0({strobe.rdEn, strobe.wrEn}));

  assert_read_latency_R7: assert property (@(posedge clk) disable iff (rst)
    outValidQ |-> $past(strobe.rdEn, 2));
endmodule

// File: rtl/burst_sram_core.sv
module burst_sram_core
  import burst_sram_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] addrIn,
  input  logic [WORD_W-1:0] dataIn,
  input  logic              chipSelN,
  input  logic              chipEnHi,
  input  logic              chipEnLoN,
  input  logic              procStartN,
  input  logic              ctrlStartN,
  input  logic              advN,
  input  logic              globalWrN,
  input  logic              writeN,
  input  logic [LANES-1:0]  laneWrN,
  input  logic              interleaveMode,
  input  logic              outEnN,
  output logic [WORD_W-1:0] dataOut,
  output logic              dataDrive
);
  sram_strobe_t strobe;
  logic [ADDR_W-1:0] accAddr;

  burst_sram_ctrl #(.ADDR_W(ADDR_W)) ctrl_i (
    .clk(clk), .rst(rst), .addrIn(addrIn),
    .chipSelN(chipSelN), .chipEnHi(chipEnHi), .chipEnLoN(chipEnLoN),
    .procStartN(procStartN), .ctrlStartN(ctrlStartN), .advN(advN),
    .globalWrN(globalWrN), .writeN(writeN), .laneWrN(laneWrN),
    .interleaveMode(interleaveMode), .strobe(strobe), .accAddr(accAddr)
  );

  burst_sram_dpath #(.ADDR_W(ADDR_W)) dpath_i (
    .clk(clk), .rst(rst), .strobe(strobe), .accAddr(accAddr),
    .dataIn(dataIn), .outEnN(outEnN), .dataOut(dataOut), .dataDrive(dataDrive)
  );
endmodule

// File: tb/burst_sram_core_tb.sv
`timescale 1ns/1ps
module burst_sram_core_tb_top;
  import burst_sram_pkg::*;
  localparam int AW = 8;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic rst, chipSelN, chipEnHi, chipEnLoN, procStartN, ctrlStartN, advN;
  logic globalWrN, writeN, interleaveMode, outEnN, dataDrive;
  logic [3:0] laneWrN;
  logic [AW-1:0] addrIn;
  logic [WORD_W-1:0] dataIn, dataOut;

  burst_sram_core #(.ADDR_W(AW)) dut_i (
    .clk(clk), .rst(rst), .addrIn(addrIn), .dataIn(dataIn),
    .chipSelN(chipSelN), .chipEnHi(chipEnHi), .chipEnLoN(chipEnLoN),
    .procStartN(procStartN), .ctrlStartN(ctrlStartN), .advN(advN),
    .globalWrN(globalWrN), .writeN(writeN), .laneWrN(laneWrN),
    .interleaveMode(interleaveMode), .outEnN(outEnN),
    .dataOut(dataOut), .dataDrive(dataDrive)
  );

  int checks = 0, errors = 0;
  logic [WORD_W-1:0] refMem [1<<AW];
  int prevMode = 0;
  logic [WORD_W-1:0] prevData = '0;
  string prevTag = "";

  // fields: tag(4) globalWrN writeN laneWrN(4) addr(8) data(36)
  localparam logic [53:0] VEC [8] = '{
    {4'd13, 1'b0, 1'b1, 4'hF,    8'h10, 36'h1_2345_6789}, // R13 full write
    {4'd13, 1'b0, 1'b1, 4'hF,    8'h11, 36'hA_BCDE_F012}, // R13 full write
    {4'd13, 1'b1, 1'b1, 4'hF,    8'h10, 36'h0},           // R13 read
    {4'd1,  1'b1, 1'b0, 4'b1010, 8'h10, 36'hF_FFFF_FFFF}, // R1 lanes 0 and 2
    {4'd1,  1'b1, 1'b1, 4'hF,    8'h10, 36'h0},           // R1 merged read
    {4'd2,  1'b0, 1'b0, 4'b0111, 8'h11, 36'h3_3333_3333}, // R2 global override
    {4'd3,  1'b1, 1'b1, 4'b0000, 8'h11, 36'h0},           // R3 read despite lane selects
    {4'd13, 1'b1, 1'b1, 4'hF,    8'h10, 36'h0}            // R13 read
  };

  task automatic check(input bit ok, input string tag,
                       input logic [WORD_W-1:0] act, input logic [WORD_W-1:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic refWrite(input logic [AW-1:0] a, input logic [WORD_W-1:0] d,
                          input logic [3:0] mask);
    for (int i = 0; i < LANES; i++)
      if (mask[i]) refMem[a][i*LANE_W +: LANE_W] = d[i*LANE_W +: LANE_W];
  endtask

  function automatic logic [AW-1:0] bAddr(input logic [AW-1:0] base, input int k,
                                          input logic ilv);
    logic [1:0] kk = k[1:0];
    return {base[AW-1:2], ilv ? (base[1:0] ^ kk) : (base[1:0] + kk)};
  endfunction

  // mode: 0 no check, 1 expect not driven, 2 expect data (checked one call later)
  task automatic step(input logic pN, cN, aN, s1N, s2, s3N, gN, wN,
                      input logic [3:0] lN, input logic [AW-1:0] a,
                      input logic [WORD_W-1:0] d, input int mode,
                      input logic [WORD_W-1:0] expD, input string tag);
    procStartN = pN; ctrlStartN = cN; advN = aN;
    chipSelN = s1N; chipEnHi = s2; chipEnLoN = s3N;
    globalWrN = gN; writeN = wN; laneWrN = lN; addrIn = a; dataIn = d;
    @(posedge clk);
    @(negedge clk);
    if (prevMode == 1)
      check(dataDrive === 1'b0, prevTag, {35'd0, dataDrive}, '0);
    else if (prevMode == 2)
      check(dataDrive === 1'b1 && dataOut === prevData, prevTag, dataOut, prevData);
    prevMode = mode; prevData = expD; prevTag = tag;
  endtask

  task automatic wrC(input logic [AW-1:0] a, input logic [WORD_W-1:0] d,
                     input logic gN, wN, input logic [3:0] lN, input string tag);
    logic [3:0] m = !gN ? 4'hF : (!wN ? ~lN : 4'h0);
    step(1, 0, 1, 0, 1, 0, gN, wN, lN, a, d, 1, '0, tag);
    refWrite(a, d, m);
  endtask

  task automatic rdC(input logic [AW-1:0] a, input logic gN, wN,
                     input logic [3:0] lN, input string tag);
    step(1, 0, 1, 0, 1, 0, gN, wN, lN, a, '0, 2, refMem[a], tag);
  endtask

  task automatic contW(input logic aN, input logic [AW-1:0] aExp,
                       input logic [WORD_W-1:0] d, input string tag);
    step(1, 1, aN, 1, 0, 1, 0, 1, 4'hF, '0, d, 1, '0, tag);
    refWrite(aExp, d, 4'hF);
  endtask

  task automatic contR(input logic aN, input logic [AW-1:0] aExp, input string tag);
    step(1, 1, aN, 1, 0, 1, 1, 1, 4'hF, '0, '0, 2, refMem[aExp], tag);
  endtask

  task automatic deselect(input int mode);
    step(1, 0, 1, 1, 1, 0, 1, 1, 4'hF, '0, '0, mode, '0, "R5");
  endtask

  initial begin
    #400000;
    checks++; errors++;
    $display("FAIL R14 watchdog actual=running expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    rst = 1; procStartN = 1; ctrlStartN = 1; advN = 1; chipSelN = 1;
    chipEnHi = 0; chipEnLoN = 1; globalWrN = 1; writeN = 1; laneWrN = 4'hF;
    addrIn = '0; dataIn = '0; interleaveMode = 0; outEnN = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check(dataDrive === 1'b0, "R14", {35'd0, dataDrive}, '0); // reset state
    rst = 0;

    // table of non-burst vectors: R13, R1, R2, R3
    for (int i = 0; i < 8; i++) begin
      logic [53:0] v = VEC[i];
      string tg = $sformatf("R%0d", v[53:50]);
      logic gN = v[49], wN = v[48];
      logic [3:0] lN = v[47:44];
      if (!gN || (!wN && lN != 4'hF)) wrC(v[43:36], v[35:0], gN, wN, lN, tg);
      else rdC(v[43:36], gN, wN, lN, tg);
    end
    deselect(1);

    // linear write burst with enables off during continue (R12, R9)
    wrC(8'h22, 36'h0_0000_0A01, 0, 1, 4'hF, "R12");
    contW(0, bAddr(8'h22, 1, 0), 36'h0_0000_0A02, "R12");
    contW(0, bAddr(8'h22, 2, 0), 36'h0_0000_0A03, "R12");
    contW(0, bAddr(8'h22, 3, 0), 36'h0_0000_0A04, "R12");
    // processor start with write controls asserted must read (R4)
    step(0, 1, 1, 0, 1, 0, 0, 0, 4'h0, 8'h22, 36'hD_EAD0_0BAD, 2, refMem[8'h22], "R4");
    contR(0, bAddr(8'h22, 1, 0), "R9");
    contR(0, bAddr(8'h22, 2, 0), "R9");
    contR(0, bAddr(8'h22, 3, 0), "R9");
    contR(1, bAddr(8'h22, 3, 0), "R11");
    // processor strobe with chipSelN high ignored; burst wraps (R6, R9)
    step(0, 1, 0, 1, 1, 0, 1, 1, 4'hF, 8'h55, '0, 2, refMem[8'h22], "R6");
    deselect(1);
    step(1, 1, 0, 1, 0, 1, 1, 1, 4'hF, '0, '0, 1, '0, "R5");
    deselect(1);

    // interleaved bursts with a suspended write (R10, R11)
    interleaveMode = 1;
    wrC(8'h31, 36'h0_0000_0B01, 0, 1, 4'hF, "R10");
    contW(0, bAddr(8'h31, 1, 1), 36'h0_0000_0B02, "R10");
    contW(1, bAddr(8'h31, 1, 1), 36'h0_0000_0B03, "R11");
    contW(0, bAddr(8'h31, 2, 1), 36'h0_0000_0B04, "R10");
    contW(0, bAddr(8'h31, 3, 1), 36'h0_0000_0B05, "R10");
    rdC(8'h31, 1, 1, 4'hF, "R10");
    contR(0, bAddr(8'h31, 1, 1), "R11");
    contR(0, bAddr(8'h31, 2, 1), "R10");
    contR(0, bAddr(8'h31, 3, 1), "R10");
    contR(0, bAddr(8'h31, 4, 1), "R10");
    deselect(1);

    // asynchronous output enable (R8)
    outEnN = 1;
    step(1, 0, 1, 0, 1, 0, 1, 1, 4'hF, 8'h30, '0, 0, '0, "R8");
    deselect(0);
    check(dataDrive === 1'b0, "R8", {35'd0, dataDrive}, '0);
    outEnN = 0;
    #0.5;
    check(dataDrive === 1'b1 && dataOut === refMem[8'h30], "R8", dataOut, refMem[8'h30]);

    // reset in the middle of a read burst (R14)
    step(1, 0, 1, 0, 1, 0, 1, 1, 4'hF, 8'h10, '0, 0, '0, "R14");
    rst = 1;
    @(posedge clk);
    @(negedge clk);
    check(dataDrive === 1'b0, "R14", {35'd0, dataDrive}, '0);
    rst = 0;
    step(1, 1, 0, 1, 0, 1, 1, 1, 4'hF, '0, '0, 1, '0, "R14");
    deselect(0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule